// File: doc/BRIEF.md
# Packed 24-bit Colour Register Loader

This block holds five 32-bit drawing-state registers: background colour, foreground colour, write mask, read mask and colour-compare value. They are loaded one byte at a time over an 8-bit write port. Each write names a register and a byte offset from 0 to 3. The block then decides which byte lane of that register takes the data.

Offsets 0 and 1 always load the two low bytes. Offsets 2 and 3 depend on the mode. With the wide-access enable set, they load the two upper bytes. With the wide-access enable clear and a 32-bit pixel depth, they follow an internal toggle flag. When the toggle is set they load the upper bytes, and when it is clear they load the lower bytes. Every offset-3 write in this mode inverts the toggle. This lets software that only reaches the upper address pair fill a full 32-bit value with two pairs of writes. In every other depth with the wide-access enable clear, offsets 2 and 3 are dropped.

A combinational read port returns any register without changing the toggle.

Top module: `color_reg_loader`

## Requirements
- R1: After reset all five registers and the toggle flag read zero.
- R2: A write at offset 0 replaces bits 7:0 and a write at offset 1 replaces bits 15:8 of the selected register, whatever the mode and toggle, and the toggle is left unchanged.
- R3: With wideEn=1, offset 2 replaces bits 23:16 and offset 3 replaces bits 31:24, and the toggle is left unchanged.
- R4: With wideEn=0, pixDepth=3 (32-bit) and toggle=1, offset 2 replaces bits 23:16 and offset 3 replaces bits 31:24.
- R5: With wideEn=0, pixDepth=3 and toggle=0, offset 2 replaces bits 7:0 and offset 3 replaces bits 15:8.
- R6: With wideEn=0 and pixDepth=3, each offset-3 write to a valid register inverts the toggle in the same edge that stores the byte. An offset-2 write leaves the toggle unchanged.
- R7: With wideEn=0 and pixDepth in 0..2, writes at offsets 2 and 3 change no register and leave the toggle unchanged.
- R8: The same lane rule applies to every register, and only the selected register changes. The regSel codes are 0 background, 1 foreground, 2 write mask, 3 read mask, 4 compare. Codes 5 to 7 change nothing, including the toggle.
- R9: rdData shows the register chosen by rdSel (same codes as R8, zero for codes 5 to 7) in the same cycle, and reading never changes the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| regSel | input | 3 | Target register code |
| byteOfs | input | 2 | Byte offset within the register address pair set |
| wrData | input | 8 | Write data byte |
| pixDepth | input | 2 | Pixel depth code, 3 = 32-bit |
| wideEn | input | 1 | Wide-access enable |
| rdSel | input | 3 | Read port register code |
| rdData | output | 32 | Read port data |
| bkgdColor | output | 32 | Background colour register |
| fgdColor | output | 32 | Foreground colour register |
| writeMask | output | 32 | Write mask register |
| readMask | output | 32 | Read mask register |
| compareColor | output | 32 | Colour-compare register |
| toggleFlag | output | 1 | Half-select toggle flag |

## Verification
On every cycle, the assertions check the following:
- A write enables at most one lane.
- Offsets 0 and 1 hit the low lanes.
- Ignored offsets enable nothing.
- The toggle inverts exactly on offset-3 writes in narrow 32-bit mode and holds otherwise.
- Each enabled lane captures the written byte, and unselected registers hold their value.

The full lane mapping, including how the toggle steers consecutive writes and the handling of codes 5 to 7, can only be shown by the bench. It sweeps every register code, depth, wide setting and offset against a byte-level model. The bench also shows that reads leave the toggle untouched.

// File: rtl/color_reg_pkg.sv
package color_reg_pkg;
  localparam int NUM_REGS  = 5;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int REG_W     = LANE_W * NUM_LANES;
  localparam int SEL_W     = 3;
  localparam int OFS_W     = 2;
  localparam int DEPTH_W   = 2;
  localparam logic [DEPTH_W-1:0] DEPTH_32 = 2'd3;

  typedef struct packed {
    logic [NUM_LANES-1:0] laneWe;
    logic [NUM_REGS-1:0]  regHit;
    logic                 flipToggle;
  } lane_strobe_t;
endpackage

// File: rtl/color_lane_ctrl.sv
module color_lane_ctrl
  import color_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [OFS_W-1:0]   byteOfs,
  input  logic [DEPTH_W-1:0] pixDepth,
  input  logic               wideEn,
  output lane_strobe_t       strb,
  output logic               toggleFlag
);
  logic selValid;
  logic narrowDeep;

  assign selValid   = (32'(regSel) < NUM_REGS);
  assign narrowDeep = !wideEn && (pixDepth == DEPTH_32);

  always_comb begin
    strb.laneWe     = '0;
    strb.flipToggle = 1'b0;
    if (wrEn && selValid) begin
      case (byteOfs)
        2'd0: strb.laneWe[0] = 1'b1;
        2'd1: strb.laneWe[1] = 1'b1;
        2'd2: begin
          if (wideEn)          strb.laneWe[2] = 1'b1;
          else if (narrowDeep) strb.laneWe[toggleFlag ? 2 : 0] = 1'b1;
        end
        default: begin
          if (wideEn)          strb.laneWe[3] = 1'b1;
          else if (narrowDeep) begin
            strb.laneWe[toggleFlag ? 3 : 1] = 1'b1;
            strb.flipToggle = 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_hit
    assign strb.regHit[gi] = wrEn && (32'(regSel) == gi);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                toggleFlag <= 1'b0;
    else if (strb.flipToggle) toggleFlag <= !toggleFlag;
  end

  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.laneWe));

  assert_low_offsets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selValid && byteOfs[1] == 1'b0) |-> $countones(strb.laneWe) == 1);

  assert_narrow_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && byteOfs[1] && !wideEn && pixDepth != DEPTH_32) |-> strb.laneWe == '0);

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selValid && byteOfs == 2'd3 && narrowDeep) |=> toggleFlag != $past(toggleFlag));

  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && selValid && byteOfs == 2'd3 && narrowDeep) |=> $stable(toggleFlag));
endmodule

// File: rtl/color_reg_datapath.sv
module color_reg_datapath
  import color_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strb,
  input  logic [LANE_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [REG_W-1:0]  regFile [NUM_REGS],
  output logic [REG_W-1:0]  rdData
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) regFile[gi] <= '0;
      else if (strb.regHit[gi]) begin
        for (int l = 0; l < NUM_LANES; l++)
          if (strb.laneWe[l]) regFile[gi][l*LANE_W +: LANE_W] <= wrData;
      end
    end

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.regHit[gi] && strb.laneWe != '0) |=> $stable(regFile[gi]));

    for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      assert_lane_store_R8: assert property (@(posedge clk) disable iff (!rstN)
        (strb.regHit[gi] && strb.laneWe[gl]) |=>
          regFile[gi][gl*LANE_W +: LANE_W] == $past(wrData));
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (32'(rdSel) == i) rdData = regFile[i];
  end
endmodule

// File: rtl/color_reg_loader.sv
module color_reg_loader
  import color_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   regSel,
  input  logic [1:0]   byteOfs,
  input  logic [7:0]   wrData,
  input  logic [1:0]   pixDepth,
  input  logic         wideEn,
  input  logic [2:0]   rdSel,
  output logic [31:0]  rdData,
  output logic [31:0]  bkgdColor,
  output logic [31:0]  fgdColor,
  output logic [31:0]  writeMask,
  output logic [31:0]  readMask,
  output logic [31:0]  compareColor,
  output logic         toggleFlag
);
  lane_strobe_t      strb;
  logic [REG_W-1:0]  regFile [NUM_REGS];

  color_lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .byteOfs(byteOfs),
    .pixDepth(pixDepth), .wideEn(wideEn), .strb(strb), .toggleFlag(toggleFlag)
  );

  color_reg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .regFile(regFile), .rdData(rdData)
  );

  assign bkgdColor    = regFile[0];
  assign fgdColor     = regFile[1];
  assign writeMask    = regFile[2];
  assign readMask     = regFile[3];
  assign compareColor = regFile[4];
endmodule

// File: tb/color_reg_loader_tb.sv
module color_reg_loader_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [1:0]  byteOfs = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  pixDepth = '0;
  logic        wideEn = 1'b0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData, bkgdColor, fgdColor, writeMask, readMask, compareColor;
  logic        toggleFlag;

  int checks = 0;
  int errors = 0;
  logic [31:0] expReg [5];
  logic        expTog = 1'b0;

  always #10 clk = !clk;

  color_reg_loader u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .byteOfs(byteOfs),
    .wrData(wrData), .pixDepth(pixDepth), .wideEn(wideEn), .rdSel(rdSel),
    .rdData(rdData), .bkgdColor(bkgdColor), .fgdColor(fgdColor),
    .writeMask(writeMask), .readMask(readMask), .compareColor(compareColor),
    .toggleFlag(toggleFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dutReg(input int i);
    case (i)
      0: return bkgdColor;
      1: return fgdColor;
      2: return writeMask;
      3: return readMask;
      default: return compareColor;
    endcase
  endfunction

  task automatic checkAll(input string tag, input string togTag);
    for (int i = 0; i < 5; i++) chk(tag, dutReg(i), expReg[i]);
    chk(togTag, {31'b0, toggleFlag}, {31'b0, expTog});
  endtask

  task automatic doWrite(input int r, input int o, input int d, input int w, input logic [7:0] val);
    int lane;
    string tag, togTag;
    @(negedge clk);
    wrEn = 1'b1; regSel = 3'(r); byteOfs = 2'(o); pixDepth = 2'(d);
    wideEn = w[0]; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    lane = -1;
    togTag = "R2";
    if (o < 2) begin lane = o; tag = "R2"; end
    else if (w != 0) begin lane = o; tag = "R3"; togTag = "R3"; end
    else if (d == 3) begin
      lane = expTog ? o : o - 2;
      tag = expTog ? "R4" : "R5";
      togTag = "R6";
    end else begin tag = "R7"; togTag = "R7"; end
    if (r >= 5) begin tag = "R8"; togTag = "R8"; end
    if (r < 5 && lane >= 0) expReg[r][lane*8 +: 8] = val;
    if (r < 5 && o == 3 && w == 0 && d == 3) expTog = !expTog;
    checkAll(tag, togTag);
    rdSel = 3'(r);
    #1;
    chk("R9", rdData, (r < 5) ? expReg[r] : 32'h0);
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int seed = 17;
    for (int i = 0; i < 5; i++) expReg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", "R1");
    for (int r = 0; r < 8; r++)
      for (int d = 0; d < 4; d++)
        for (int w = 0; w < 2; w++)
          for (int o = 0; o < 4; o++) begin
            seed = (seed * 37 + 11) % 251;
            doWrite(r, o, d, w, 8'(seed + 1));
          end
    // Full 32-bit load through the upper pair in narrow 32-bit mode
    if (expTog) doWrite(0, 3, 3, 0, 8'h00);
    doWrite(1, 2, 3, 0, 8'h11);
    doWrite(1, 3, 3, 0, 8'h22);
    doWrite(1, 2, 3, 0, 8'h33);
    doWrite(1, 3, 3, 0, 8'h44);
    chk("R4", fgdColor, 32'h44332211);
    doWrite(2, 2, 3, 0, 8'hA5);
    chk("R6", {31'b0, toggleFlag}, 32'h0);
    doWrite(2, 3, 3, 0, 8'h5A);
    // Reads only: toggle must hold
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rdSel = 3'(k);
      @(negedge clk);
      chk("R9", rdData, (k < 5) ? expReg[k] : 32'h0);
      chk("R9", {31'b0, toggleFlag}, {31'b0, expTog});
    end
    finishRun();
  end
endmodule